// File: doc/BRIEF.md
# Serial Configuration Bitstream Readout Sequencer

This block is the read side of a bit-serial configuration store that feeds one or more FPGAs. A fixed storage image is held in a register array and organised as words. A bit counter and a word counter select one bit at a time. While the chip is selected, each rising clock moves the selection on by one bit, and the selected bit is presented on a serial data pin that has a separate drive enable.

An optional paging mode splits the image into four equal partitions, and a two-bit selector picks which partition is streamed. When the last bit of the active span has been read, a cascade output goes active so that the next device in a daisy chain can take over the download. One input combines an active-high output enable with an active-low counter clear. A serial-enable input switches the read path off entirely.

Top module: `cfg_readout`

## Requirements
- R1: While `ser_en` is high, a low `oe_rstn` sampled at a clock edge clears the bit and word counters and the finished state, so the next read starts at stream bit 0 of the active span.
- R2: `dout_en` is high only when `ser_en` is high, `ce_n` is low, `oe_rstn` is high and the span has not been finished. `dout` is 0 whenever `dout_en` is low.
- R3: While driving, `dout` shows image bit `base + s`, where `s` is the number of bits already read from the span. Each rising clock with `dout_en` high advances `s` by one.
- R4: With `ce_n` high, the counters hold their value and `dout_en` is low. After `ce_n` returns low, the stream resumes at the bit where it stopped.
- R5: With `page_en` high, the span is `DEPTH/4` bits long and starts at image bit `page_sel * DEPTH/4`.
- R6: With `page_en` low, the span starts at image bit 0 and covers all `DEPTH` bits.
- R7: The clock edge that consumes the last bit of the span sets a finished state. From then on the counters hold and `dout_en` stays low until a clear under R1.
- R8: Once the span is finished, `ceo_n` equals `ce_n`. It is therefore low while `ce_n` stays low and follows any change of `ce_n`.
- R9: After a clear under R1, `ceo_n` stays high until the span has been read to its end again.
- R10: While `ser_en` is low, `dout_en` is low and `ceo_n` is high. The counters, the finished state and the cascade state hold, and `oe_rstn`, `ce_n`, `page_en` and `page_sel` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_en | input | 1 | High selects the read path; low means programming mode, and the read path is idle |
| oe_rstn | input | 1 | High enables output; low clears the counters |
| ce_n | input | 1 | Active-low chip select; high puts the block in standby |
| page_en | input | 1 | High splits the image into four pages |
| page_sel | input | 2 | Page picked when paging is on |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Drive enable for the data pin; low means high-impedance |
| ceo_n | output | 1 | Active-low cascade output to the next device |

## Verification
The hardest state to reach is the cascade hold after an output-enable pulse. It only exists after a complete span has been clocked through. The stimulus reads all 1024 bits of the unpaged image, and all 256 bits of each page, through the scoreboard. It then toggles `ce_n` to show the follow behaviour and pulses `oe_rstn` low. A partial re-read then shows that `ceo_n` stays high. A programming-mode window contains a clear attempt. Because the stream resumes at the same bit after that window, the bench can show that the clear was ignored.

// File: rtl/cfg_readout_pkg.sv
package cfg_readout_pkg;

  typedef struct packed {
    logic run;
    logic clr;
  } rd_ctl_t;

endpackage

// File: rtl/cfg_rd_counter.sv
module cfg_rd_counter
  import cfg_readout_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned WORDS  = 128,
  localparam int unsigned BAW   = $clog2(WORD_W),
  localparam int unsigned WAW   = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  rd_ctl_t        ctl,
  input  logic [WAW-1:0] last_word,
  output logic [WAW-1:0] word_q,
  output logic [BAW-1:0] bit_q,
  output logic           done_q,
  output logic           end_hit
);

  logic [WAW-1:0] word_d;
  logic [BAW-1:0] bit_d;
  logic           done_d;
  logic           last_bit;

  assign last_bit = (bit_q == BAW'(WORD_W - 1));
  assign end_hit  = ctl.run && last_bit && (word_q == last_word);

  always_comb begin
    word_d = word_q;
    bit_d  = bit_q;
    done_d = done_q;
    if (ctl.clr) begin
      word_d = '0;
      bit_d  = '0;
      done_d = 1'b0;
    end else if (ctl.run) begin
      if (end_hit) begin
        done_d = 1'b1;
      end else if (last_bit) begin
        bit_d  = '0;
        word_d = word_q + WAW'(1);
      end else begin
        bit_d = bit_q + BAW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      word_q <= word_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (word_q == '0) && (bit_q == '0) && !done_q); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctl.clr) |=> $stable(word_q) && $stable(bit_q) && $stable(done_q)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctl.clr) |=> done_q); // R7
  AST_NO_RUN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !ctl.run); // R7

endmodule

// File: rtl/cfg_rd_store.sv
module cfg_rd_store #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned WORD_W = 8,
  parameter logic [DEPTH-1:0] IMAGE = {(DEPTH/32){32'hA5C3_3C96}},
  localparam int unsigned WORDS = DEPTH / WORD_W,
  localparam int unsigned BAW   = $clog2(WORD_W),
  localparam int unsigned WAW   = $clog2(WORDS)
) (
  input  logic [WAW-1:0] word_abs,
  input  logic [BAW-1:0] bit_sel,
  output logic           bit_o
);

  logic [WORD_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign mem[g] = IMAGE[g*WORD_W +: WORD_W];
  end

  assign bit_o = mem[word_abs][bit_sel];

endmodule

// File: rtl/cfg_rd_cascade.sv
module cfg_rd_cascade (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic oe_rstn,
  input  logic ce_n,
  input  logic end_hit,
  output logic ceo_n
);

  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (ser_en) begin
      if (!oe_rstn)    armed_d = 1'b0;
      else if (end_hit) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign ceo_n = (ser_en && armed_q) ? ce_n : 1'b1;

  AST_ARM_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> armed_q); // R8
  AST_PROG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> ceo_n); // R10
  AST_OE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !oe_rstn) |=> ceo_n); // R9

endmodule

// File: rtl/cfg_readout.sv
module cfg_readout
  import cfg_readout_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned WORD_W = 8,
  parameter logic [DEPTH-1:0] IMAGE = {(DEPTH/32){32'hA5C3_3C96}}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_en,
  input  logic       oe_rstn,
  input  logic       ce_n,
  input  logic       page_en,
  input  logic [1:0] page_sel,
  output logic       dout,
  output logic       dout_en,
  output logic       ceo_n
);

  localparam int unsigned WORDS      = DEPTH / WORD_W;
  localparam int unsigned PAGE_WORDS = WORDS / 4;
  localparam int unsigned BAW        = $clog2(WORD_W);
  localparam int unsigned WAW        = $clog2(WORDS);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  rd_ctl_t        ctl;
  logic [WAW-1:0] last_word;
  logic [WAW-1:0] base_word;
  logic [WAW-1:0] word_q;
  logic [WAW-1:0] word_abs;
  logic [BAW-1:0] bit_q;
  logic           done_q;
  logic           end_hit;
  logic           store_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    ctl.clr = ser_en && !oe_rstn;
    ctl.run = ser_en && oe_rstn && !ce_n && !done_q;
  end

  always_comb begin
    if (page_en) begin
      last_word = WAW'(PAGE_WORDS - 1);
      base_word = WAW'(page_sel) * WAW'(PAGE_WORDS);
    end else begin
      last_word = WAW'(WORDS - 1);
      base_word = '0;
    end
  end

  assign word_abs = base_word + word_q;

  cfg_rd_counter #(.WORD_W(WORD_W), .WORDS(WORDS)) i_counter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl       (ctl),
    .last_word (last_word),
    .word_q    (word_q),
    .bit_q     (bit_q),
    .done_q    (done_q),
    .end_hit   (end_hit)
  );

  cfg_rd_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .IMAGE(IMAGE)) i_store (
    .word_abs (word_abs),
    .bit_sel  (bit_q),
    .bit_o    (store_bit)
  );

  cfg_rd_cascade i_cascade (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ser_en  (ser_en),
    .oe_rstn (oe_rstn),
    .ce_n    (ce_n),
    .end_hit (end_hit),
    .ceo_n   (ceo_n)
  );

  assign dout_en = ctl.run;
  assign dout    = dout_en && store_bit;

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_int_n)
    ce_n |-> !dout_en); // R4
  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ser_en |-> !dout_en); // R10
  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dout_en |-> !dout); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(end_hit) |-> !dout_en); // R7

endmodule

// File: tb/test_cfg_readout.sv
module test_cfg_readout;

  localparam int DEPTH = 1024;
  localparam int PAGE  = DEPTH / 4;

  function automatic logic [DEPTH-1:0] make_pat();
    logic [DEPTH-1:0] p;
    for (int i = 0; i < DEPTH; i++) p[i] = (((i * 37) + (i >> 4)) % 7) < 3;
    return p;
  endfunction

  localparam logic [DEPTH-1:0] PAT = make_pat();

  logic       clk = 1'b0;
  logic       rst_n, ser_en, oe_rstn, ce_n, page_en;
  logic [1:0] page_sel;
  logic       dout, dout_en, ceo_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic  exp_q[$];
  string cur_req = "R3";

  always #4 clk = ~clk;

  cfg_readout #(.DEPTH(DEPTH), .WORD_W(8), .IMAGE(PAT)) i_cfg_readout (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .oe_rstn(oe_rstn), .ce_n(ce_n),
    .page_en(page_en), .page_sel(page_sel), .dout(dout), .dout_en(dout_en), .ceo_n(ceo_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  // driver: push expected stream bits, one per clock
  task automatic read_bits(input int base, input int start, input int n, input string req);
    cur_req = req;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(PAT[base + start + k]);
      @(posedge clk); #1;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && dout_en === 1'b1) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected drive act=%0d exp=no-drive t=%0t", dout, $time);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (dout !== e) begin
          n_bad++;
          $display("FAIL %s act=%0d exp=%0d t=%0t", cur_req, dout, e, $time);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_en = 1'b1; oe_rstn = 1'b0; ce_n = 1'b1; page_en = 1'b0; page_sel = 2'd0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk(dout_en == 1'b0, "R2 reset drive", dout_en, 0);
    chk(ceo_n == 1'b1, "R9 reset cascade", ceo_n, 1);

    // unpaged full read
    oe_rstn = 1'b1; ce_n = 1'b0; #1;
    chk(ceo_n == 1'b1, "R9 cascade before end", ceo_n, 1);
    read_bits(0, 0, DEPTH, "R6");
    chk(dout_en == 1'b0, "R7 released at end", dout_en, 0);
    chk(ceo_n == 1'b0, "R8 cascade low at end", ceo_n, 0);
    tick(3);
    chk(dout_en == 1'b0, "R7 held after end", dout_en, 0);
    ce_n = 1'b1; #1;
    chk(ceo_n == 1'b1, "R8 follows ce high", ceo_n, 1);
    tick(1);
    ce_n = 1'b0; #1;
    chk(ceo_n == 1'b0, "R8 follows ce low", ceo_n, 0);

    // oe pulse: counter clear and cascade hold
    oe_rstn = 1'b0; tick(1);
    chk(ceo_n == 1'b1, "R9 after oe low", ceo_n, 1);
    oe_rstn = 1'b1; #1;
    chk(ceo_n == 1'b1, "R9 held high", ceo_n, 1);
    read_bits(0, 0, 10, "R1");
    chk(ceo_n == 1'b1, "R9 high mid-read", ceo_n, 1);

    // clear mid-read
    oe_rstn = 1'b0; tick(1); oe_rstn = 1'b1;
    read_bits(0, 0, 6, "R1");

    // standby
    ce_n = 1'b1; #1;
    chk(dout_en == 1'b0, "R4 standby hiz", dout_en, 0);
    tick(4);
    chk(dout_en == 1'b0, "R4 standby still hiz", dout_en, 0);
    ce_n = 1'b0;
    read_bits(0, 6, 4, "R4");

    // programming mode
    ser_en = 1'b0; #1;
    chk(dout_en == 1'b0, "R10 prog hiz", dout_en, 0);
    chk(ceo_n == 1'b1, "R10 prog cascade", ceo_n, 1);
    tick(3);
    oe_rstn = 1'b0; page_en = 1'b1; page_sel = 2'd3; tick(2);
    oe_rstn = 1'b1; page_en = 1'b0; page_sel = 2'd0; #1;
    chk(dout_en == 1'b0, "R10 prog still hiz", dout_en, 0);
    ser_en = 1'b1;
    read_bits(0, 10, 3, "R10");

    // paged reads
    page_en = 1'b1;
    for (int p = 0; p < 4; p++) begin
      page_sel = 2'(p);
      oe_rstn = 1'b0; tick(1); oe_rstn = 1'b1;
      read_bits(p * PAGE, 0, PAGE, "R5");
      chk(dout_en == 1'b0, "R7 page end released", dout_en, 0);
      chk(ceo_n == 1'b0, "R8 page end cascade", ceo_n, 0);
    end

    tick(2);
    summary();
    $finish;
  end

endmodule